// File: doc/BRIEF.md
# Watchdog Timer with Guarded Configuration

This block is a watchdog peripheral for a small microcontroller. The CPU reaches it through one 8-bit control/status register. It also drives a restart strobe from its watchdog-restart instruction and has write access to a status register that holds the watchdog reset-cause bit. The block counts enable pulses from the slow watchdog clock domain. When a programmed number of ticks passes without a restart, it raises an interrupt, requests a system reset, or does both in turn: the interrupt on the first expiry and the reset on the next.

The timeout select bits and the reset-enable bit are locked against stray writes. Software first writes a special unlock pattern, which opens a short window of CPU clock cycles. A write inside that window may change the locked bits. A write outside it changes only the unlocked bits. The flag, enable and cause outputs are registered, so the block fits directly beside an interrupt controller and a reset sequencer.

Top module: `wdog_core`

## Requirements
- R1: After a synchronous reset, the control register reads 0x00, and irq, sys_rst_req and rst_cause are all 0.
- R2: Control register fields are: bit 7 expiry flag, bit 6 interrupt enable, bit 5 timeout select bit 3, bit 4 unlock key, bit 3 reset enable, bits 2:0 timeout select bits 2:0. Bit 6 can be written at any time. Bit 4 always reads 0.
- R3: A write with bits 4 and 3 both set is an unlock. It leaves the register unchanged and opens a window. Writes on the WIN_CYCLES clock edges that follow may change bits 5, 3 and 2:0.
- R4: A write that is not an unlock and that falls outside the window leaves bits 5, 3 and 2:0 unchanged.
- R5: The timeout is 2^(BASE_LOG2+s) counted tick_en pulses. Here s is {bit5, bits2:0}, and values above MAX_CODE count as MAX_CODE. Cycles without tick_en do not count.
- R6: The counter runs only while bit 6 or bit 3 is set. While both are clear, no expiry, flag or reset request occurs.
- R7: The counter restarts from zero on wdr_strobe and on every control register write. A strobe on the edge where the last tick would expire prevents that expiry.
- R8: Interrupt mode: at expiry with bit 6 set, the flag is set and the counter reloads and keeps counting. irq equals flag AND bit 6.
- R9: Combined mode: with bits 6 and 3 both set, the first expiry sets the flag and clears bit 6. The next expiry after it requests a reset.
- R10: At expiry with bit 3 set and bit 6 clear, sys_rst_req pulses for one cycle, and rst_cause (status bit 3) is set in the same cycle.
- R11: rst_cause clears when the status register is written with bit 3 at 0. A reset expiry in the same cycle wins, and the bit stays 1.
- R12: Writing 1 to control bit 7 clears the flag. Writing 0 to bit 7 leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-cycle pulse per watchdog base-clock period |
| wdr_strobe | input | 1 | Restart request from the CPU |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| stat_wr | input | 1 | Status register write strobe |
| stat_wdata | input | 8 | Status register write data; bit 3 is the reset-cause bit |
| ctrl_rdata | output | 8 | Control register read value |
| irq | output | 1 | Interrupt request |
| sys_rst_req | output | 1 | One-cycle system reset request |
| rst_cause | output | 1 | Watchdog reset-cause bit |

## Verification
Two pairs of events can land on the same clock edge, and the bench forces each pair to meet.

The first pair is a restart strobe and the final tick of a period. The bench counts ticks from the write that armed the counter and places the strobe exactly on the expiry edge. It then checks that the flag stays clear for one more full period and rises only when that period ends.

The second pair is a clear of the reset-cause bit and a reset expiry. The bench issues the clear on the very edge where the reset request fires. It expects rst_cause to read 1 after that edge, and expects a second clear one cycle later to drop it to 0.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  // control register bit positions
  localparam int unsigned B_FLAG = 7;
  localparam int unsigned B_IE   = 6;
  localparam int unsigned B_SEL3 = 5;
  localparam int unsigned B_KEY  = 4;
  localparam int unsigned B_RE   = 3;
  localparam int unsigned B_SELH = 2;
  // status register bit holding the watchdog reset cause
  localparam int unsigned B_CAUSE = 3;
  // bits guarded by the unlock window
  localparam logic [7:0] GUARD_MASK = 8'h2F;

  function automatic logic [3:0] sel_of(input logic [7:0] r);
    return {r[B_SEL3], r[B_SELH:0]};
  endfunction
endpackage

// File: rtl/wdog_unlock.sv
module wdog_unlock #(
  parameter int unsigned WIN_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr,
  input  logic [7:0] wdata,
  output logic       unlock,
  output logic       win_open
);
  import wdog_pkg::*;
  localparam int unsigned WW = $clog2(WIN_CYCLES + 1);

  logic [WW-1:0] win_q;

  assign unlock   = wr && wdata[B_KEY] && wdata[B_RE];
  assign win_open = (win_q != '0);

  always_ff @(posedge clk) begin
    if (rst)           win_q <= '0;
    else if (unlock)   win_q <= WW'(WIN_CYCLES);
    else if (win_open) win_q <= win_q - 1'b1;
  end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int unsigned BASE_LOG2 = 11,
  parameter int unsigned MAX_CODE  = 9
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            tick,
  input  logic                            run,
  input  logic                            restart,
  input  logic [3:0]                      sel,
  output logic                            expire,
  output logic [BASE_LOG2+MAX_CODE:0]     cnt
);
  localparam int unsigned CNT_W = BASE_LOG2 + MAX_CODE + 1;

  logic [3:0]       sel_eff;
  logic [CNT_W-1:0] limit_m1;

  always_comb begin
    sel_eff  = (sel > 4'(MAX_CODE)) ? 4'(MAX_CODE) : sel;
    limit_m1 = (CNT_W'(1) << (BASE_LOG2 + int'(sel_eff))) - CNT_W'(1);
  end

  assign expire = run && tick && !restart && (cnt == limit_m1);

  always_ff @(posedge clk) begin
    if (rst || restart || !run) cnt <= '0;
    else if (tick) begin
      if (cnt == limit_m1) cnt <= '0;
      else                 cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr,
  input  logic [7:0] wdata,
  input  logic       unlock,
  input  logic       win_open,
  input  logic       expire,
  input  logic       stat_wr,
  input  logic [7:0] stat_wdata,
  output logic [7:0] ctrl_q,
  output logic       irq_q,
  output logic       rst_req_q,
  output logic       cause_q
);
  import wdog_pkg::*;

  logic [7:0] nxt;
  logic       rst_hit;

  always_comb begin
    nxt = ctrl_q;
    if (wr && !unlock) begin
      nxt[B_IE] = wdata[B_IE];
      if (wdata[B_FLAG]) nxt[B_FLAG] = 1'b0;
      if (win_open) nxt = (nxt & ~GUARD_MASK) | (wdata & GUARD_MASK);
    end else if (expire && ctrl_q[B_IE]) begin
      nxt[B_FLAG] = 1'b1;
      if (ctrl_q[B_RE]) nxt[B_IE] = 1'b0;
    end
    nxt[B_KEY] = 1'b0;
  end

  assign rst_hit = expire && ctrl_q[B_RE] && !ctrl_q[B_IE];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      irq_q     <= 1'b0;
      rst_req_q <= 1'b0;
      cause_q   <= 1'b0;
    end else begin
      ctrl_q    <= nxt;
      irq_q     <= nxt[B_FLAG] & nxt[B_IE];
      rst_req_q <= rst_hit;
      if (rst_hit)                             cause_q <= 1'b1;
      else if (stat_wr && !stat_wdata[B_CAUSE]) cause_q <= 1'b0;
    end
  end
endmodule

// File: rtl/wdog_core.sv
module wdog_core #(
  parameter int unsigned BASE_LOG2  = 11,
  parameter int unsigned MAX_CODE   = 9,
  parameter int unsigned WIN_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_en,
  input  logic       wdr_strobe,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  input  logic       stat_wr,
  input  logic [7:0] stat_wdata,
  output logic [7:0] ctrl_rdata,
  output logic       irq,
  output logic       sys_rst_req,
  output logic       rst_cause
);
  import wdog_pkg::*;
  localparam int unsigned CNT_W = BASE_LOG2 + MAX_CODE + 1;

  logic             unlock, win_open, expire, run, restart;
  logic [7:0]       ctrl_q;
  logic [CNT_W-1:0] tick_cnt;

  assign run     = ctrl_q[B_IE] | ctrl_q[B_RE];
  assign restart = wdr_strobe | reg_wr;

  wdog_unlock #(.WIN_CYCLES(WIN_CYCLES)) u_unlock (
    .clk(clk), .rst(rst), .wr(reg_wr), .wdata(reg_wdata),
    .unlock(unlock), .win_open(win_open)
  );

  wdog_counter #(.BASE_LOG2(BASE_LOG2), .MAX_CODE(MAX_CODE)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick_en), .run(run), .restart(restart),
    .sel(sel_of(ctrl_q)), .expire(expire), .cnt(tick_cnt)
  );

  wdog_regs u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .wdata(reg_wdata),
    .unlock(unlock), .win_open(win_open), .expire(expire),
    .stat_wr(stat_wr), .stat_wdata(stat_wdata),
    .ctrl_q(ctrl_q), .irq_q(irq), .rst_req_q(sys_rst_req), .cause_q(rst_cause)
  );

  assign ctrl_rdata = ctrl_q;
endmodule

// File: rtl/wdog_core_chk.sv
module wdog_core_chk #(
  parameter int unsigned CNT_W = 21
) (
  input logic             clk,
  input logic             rst,
  input logic             reg_wr,
  input logic [7:0]       reg_wdata,
  input logic             wdr_strobe,
  input logic [7:0]       ctrl_rdata,
  input logic             irq,
  input logic             sys_rst_req,
  input logic             rst_cause,
  input logic             win_open,
  input logic [CNT_W-1:0] cnt
);
  logic key_wr;
  assign key_wr = reg_wr && reg_wdata[4] && reg_wdata[3];

  p_key_bit_zero_r2: assert property (@(posedge clk) disable iff (rst)
    ctrl_rdata[4] == 1'b0);

  p_unlock_holds_r3: assert property (@(posedge clk) disable iff (rst)
    key_wr |=> $stable(ctrl_rdata));

  p_guard_kept_r4: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && !key_wr && !win_open) |=> ((ctrl_rdata & 8'h2F) == $past(ctrl_rdata & 8'h2F)));

  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    !(ctrl_rdata[6] || ctrl_rdata[3]) |=> (!sys_rst_req && !$rose(ctrl_rdata[7])));

  p_strobe_restart_r7: assert property (@(posedge clk) disable iff (rst)
    wdr_strobe |=> (cnt == '0));

  p_irq_gate_r8: assert property (@(posedge clk) disable iff (rst)
    irq == (ctrl_rdata[7] && ctrl_rdata[6]));

  p_rst_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    sys_rst_req |=> !sys_rst_req);

  p_rst_cause_r10: assert property (@(posedge clk) disable iff (rst)
    sys_rst_req |-> rst_cause);

  p_flag_clear_r12: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && !key_wr && reg_wdata[7]) |=> !ctrl_rdata[7]);
endmodule

bind wdog_core wdog_core_chk #(.CNT_W(BASE_LOG2 + MAX_CODE + 1)) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
  .wdr_strobe(wdr_strobe), .ctrl_rdata(ctrl_rdata), .irq(irq),
  .sys_rst_req(sys_rst_req), .rst_cause(rst_cause),
  .win_open(win_open), .cnt(tick_cnt)
);

// File: tb/wdog_core_bench.sv
module wdog_core_bench;
  localparam int unsigned BL = 2;
  localparam int unsigned MC = 9;
  localparam int unsigned WC = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_en = 1'b1;
  logic       wdr_strobe = 1'b0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic       stat_wr = 1'b0;
  logic [7:0] stat_wdata = 8'h00;
  logic [7:0] ctrl_rdata;
  logic       irq, sys_rst_req, rst_cause;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  wdog_core #(.BASE_LOG2(BL), .MAX_CODE(MC), .WIN_CYCLES(WC)) u_wdog_core (
    .clk(clk), .rst(rst), .tick_en(tick_en), .wdr_strobe(wdr_strobe),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .stat_wr(stat_wr),
    .stat_wdata(stat_wdata), .ctrl_rdata(ctrl_rdata), .irq(irq),
    .sys_rst_req(sys_rst_req), .rst_cause(rst_cause)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic wr(input logic [7:0] d);
    reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = 8'h00;
  endtask
  task automatic stb();
    wdr_strobe = 1'b1;
    @(negedge clk);
    wdr_strobe = 1'b0;
  endtask
  task automatic stwr(input logic [7:0] d);
    stat_wr = 1'b1; stat_wdata = d;
    @(negedge clk);
    stat_wr = 1'b0; stat_wdata = 8'h00;
  endtask
  function automatic logic [7:0] enc(input logic ie, input logic re, input logic [3:0] s);
    return {1'b1, ie, s[3], 1'b0, re, s[2:0]};
  endfunction
  task automatic set_cfg(input logic ie, input logic re, input logic [3:0] s);
    wr(8'h18);
    wr(enc(ie, re, s));
  endtask
  function automatic int lim(input int s);
    return (1 << BL) << ((s > MC) ? MC : s);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    idle(3);
    rst = 1'b0;
    // R1 reset state
    chk("R1 ctrl", 32'(ctrl_rdata), 32'h00);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 sys_rst_req", 32'(sys_rst_req), 0);
    chk("R1 rst_cause", 32'(rst_cause), 0);

    // R4 guarded bits ignored without unlock; R2 bit 6 free, bit 4 reads 0
    wr(8'h2F);
    chk("R4 guarded write ignored", 32'(ctrl_rdata), 32'h00);
    wr(8'h50);
    chk("R2 ie write, key bit reads 0", 32'(ctrl_rdata), 32'h40);
    wr(8'h00);

    // R5/R8/R12 sweep of every select code
    for (int s = 0; s < 16; s++) begin
      set_cfg(1'b1, 1'b0, 4'(s));
      chk("R3 guarded bits written in window", 32'(ctrl_rdata), 32'(enc(1'b1, 1'b0, 4'(s)) & 8'h6F));
      idle(lim(s) - 1);
      chk("R5 no flag before timeout", 32'(ctrl_rdata[7]), 0);
      idle(1);
      chk("R5 flag at timeout", 32'(ctrl_rdata[7]), 1);
      chk("R8 irq raised", 32'(irq), 1);
      wr(8'hC0);
      chk("R12 flag cleared, R4 select kept", 32'(ctrl_rdata), 32'(enc(1'b1, 1'b0, 4'(s)) & 8'h6F));
      chk("R8 irq dropped", 32'(irq), 0);
    end

    // R3/R4 window length: writes d idle cycles after the unlock
    for (int d = 0; d < 6; d++) begin
      set_cfg(1'b0, 1'b0, 4'd0);
      wr(8'h18);
      idle(d);
      wr(8'h07);
      chk((d < WC) ? "R3 write inside window" : "R4 write after window",
          32'(ctrl_rdata), (d < WC) ? 32'h07 : 32'h00);
    end

    // R3 unlock write leaves the register unchanged
    set_cfg(1'b1, 1'b0, 4'd5);
    wr(8'h18);
    chk("R3 unlock leaves register", 32'(ctrl_rdata), 32'h45);

    // R6 disabled: nothing happens
    set_cfg(1'b0, 1'b0, 4'd0);
    idle(3000);
    chk("R6 no flag when idle", 32'(ctrl_rdata[7]), 0);
    chk("R6 no cause when idle", 32'(rst_cause), 0);

    // R5 only tick_en pulses count
    set_cfg(1'b1, 1'b0, 4'd0);
    tick_en = 1'b0;
    idle(40);
    chk("R5 no count without ticks", 32'(ctrl_rdata[7]), 0);
    tick_en = 1'b1;
    idle(3);
    chk("R5 three ticks", 32'(ctrl_rdata[7]), 0);
    idle(1);
    chk("R5 fourth tick expires", 32'(ctrl_rdata[7]), 1);

    // R7 strobe on the expiry edge
    set_cfg(1'b1, 1'b0, 4'd0);
    idle(3);
    stb();
    chk("R7 strobe beats expiry", 32'(ctrl_rdata[7]), 0);
    idle(3);
    chk("R7 restarted period", 32'(ctrl_rdata[7]), 0);
    idle(1);
    chk("R7 expiry after restart", 32'(ctrl_rdata[7]), 1);
    // R8 ie off masks irq but keeps flag
    wr(8'h00);
    chk("R8 flag kept", 32'(ctrl_rdata[7]), 1);
    chk("R8 irq masked", 32'(irq), 0);

    // R9 combined mode
    set_cfg(1'b1, 1'b1, 4'd0);
    idle(4);
    chk("R9 first expiry: flag set, ie cleared", 32'(ctrl_rdata[7:6]), 32'b10);
    chk("R9 no reset at first expiry", 32'(sys_rst_req), 0);
    idle(3);
    chk("R9 no reset early", 32'(sys_rst_req), 0);
    idle(1);
    chk("R9 reset at second expiry", 32'(sys_rst_req), 1);
    chk("R10 cause set", 32'(rst_cause), 1);
    idle(1);
    chk("R10 single pulse", 32'(sys_rst_req), 0);
    stwr(8'h00);
    chk("R11 cause cleared", 32'(rst_cause), 0);

    // R10 reset mode with select 1
    set_cfg(1'b0, 1'b1, 4'd1);
    idle(7);
    chk("R10 no reset early", 32'(sys_rst_req), 0);
    idle(1);
    chk("R10 reset request", 32'(sys_rst_req), 1);
    chk("R10 cause", 32'(rst_cause), 1);
    stwr(8'h08);
    chk("R11 writing 1 keeps cause", 32'(rst_cause), 1);
    stwr(8'h00);
    chk("R11 cause cleared", 32'(rst_cause), 0);

    // R11 clear on the same edge as a reset expiry
    set_cfg(1'b0, 1'b1, 4'd0);
    idle(3);
    stwr(8'h00);
    chk("R11 collision reset req", 32'(sys_rst_req), 1);
    chk("R11 set wins over clear", 32'(rst_cause), 1);
    stwr(8'h00);
    chk("R11 later clear", 32'(rst_cause), 0);
    set_cfg(1'b0, 1'b0, 4'd0);
    idle(2);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule